// File: doc/BRIEF.md
# Synchronous Dual-Ratio Clock Divider

This block takes one input clock and produces two divided clocks from it: a half-rate clock and a slower clock whose ratio is one quarter or one sixth of the input rate, chosen by a mode input. Both outputs are registered on the rising input edge from one shared position counter. Every rising edge of the slow clock therefore falls on the same input edge as a rising edge of the half-rate clock. A third output gives a one-cycle marker on each input cycle in which both divided clocks have just risen together. Downstream logic can use this marker to find the common phase.

The run/stop input is captured by a flop on the falling input edge, so its value only changes while the input clock is low. A stop request does not cut a slow period short. The divider runs on to the last, all-low position of the current slow period and parks there. When the request is raised again, both outputs rise together from that parked position. A synchronous, active-high reset parks the counter at the same all-low position. Several instances that leave reset on the same edge then run in step.

Top module: `dual_ratio_div`

## Requirements
- R1: While running, the half-rate output is high for exactly one input cycle and low for exactly one input cycle.
- R2: With the mode input low, the slow output is high for two input cycles and then low for two, a period of four.
- R3: With the mode input high, the slow output is high for three input cycles and then low for three, a period of six.
- R4: Every rising edge of the slow output appears on the same input edge as a rising edge of the half-rate output.
- R5: The phase marker is high for exactly the input cycles in which both divided outputs have just risen, and low in every other cycle.
- R6: The run/stop input is sampled on the falling input edge. A change made after a falling edge has no effect on the rising edge that follows it, and acts one rising edge later.
- R7: A stop request that arrives mid-period lets the current slow period finish in full. No high phase of either output is ever shorter than its nominal length, except one cut by reset.
- R8: Once stopped, all three outputs stay low and the divider position is held.
- R9: Reset, synchronous and active high, drives all three outputs low on the next rising edge. The first running edge after reset raises both divided outputs and the phase marker together.
- R10: After a stop, the first running edge raises both divided outputs and the phase marker together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Input clock; outputs switch on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run/stop request, captured on the falling edge of clkIn |
| sixMode | input | 1 | Slow output ratio: 0 divides by 4, 1 divides by 6 |
| halfClk | output | 1 | Input clock divided by 2 |
| slowClk | output | 1 | Input clock divided by 4 or 6, 50% duty |
| phaseMark | output | 1 | One-cycle pulse when both divided outputs rise together |

## Verification
The bench builds the divider with its default ratios, 4 and 6, so both modes and the switch between them through reset can be checked against exact cycle-by-cycle predictions. These small ratios keep full slow periods short. Stops in the middle of a period, a run/stop change placed just after a falling edge, and a reset in the middle of a period all fit within a few dozen cycles. The monitor also measures the length of each high phase and checks that every slow rising edge coincides with a half-rate rising edge.

// File: rtl/drd_pkg.sv
package drd_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic step;  // advance the divider on this rising edge
    logic wrap;  // position is terminal: next position is zero
  } drd_strobe_t;

endpackage

// File: rtl/drd_ctrl.sv
module drd_ctrl
  import drd_pkg::*;
(
  input  logic        clkIn,
  input  logic        enable,
  input  logic        atTerm,
  output drd_strobe_t stb
);

  logic enLatch;

  // Run request captured while the clock is low
  always_ff @(negedge clkIn) begin
    enLatch <= enable;
  end

  // A running divider always finishes its slow period before parking
  always_comb begin
    stb.step = enLatch | ~atTerm;
    stb.wrap = atTerm;
  end

endmodule

// File: rtl/drd_datapath.sv
module drd_datapath
  import drd_pkg::*;
#(
  parameter int RATIO_LO = 4,
  parameter int RATIO_HI = 6
) (
  input  logic        clkIn,
  input  logic        rst,
  input  logic        sixMode,
  input  drd_strobe_t stb,
  output logic        atTerm,
  output logic        halfClk,
  output logic        slowClk,
  output logic        phaseMark
);

  localparam int CNT_W = $clog2(RATIO_HI);
  localparam logic [CNT_W:0] LO_N = RATIO_LO[CNT_W:0];
  localparam logic [CNT_W:0] HI_N = RATIO_HI[CNT_W:0];
  localparam logic [CNT_W-1:0] PARK = CNT_W'(RATIO_HI - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] nextCnt;
  logic [CNT_W:0]   ratioN;
  logic [CNT_W:0]   halfN;
  logic             halfQ;
  logic             slowQ;
  logic             phaseQ;

  always_comb begin
    ratioN  = sixMode ? HI_N : LO_N;
    halfN   = ratioN >> 1;
    atTerm  = ({1'b0, cnt} >= (ratioN - 1'b1));
    nextCnt = stb.wrap ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clkIn) begin
    if (rst) begin
      cnt    <= PARK;
      halfQ  <= 1'b0;
      slowQ  <= 1'b0;
      phaseQ <= 1'b0;
    end else if (stb.step) begin
      cnt    <= nextCnt;
      halfQ  <= ~nextCnt[0];
      slowQ  <= ({1'b0, nextCnt} < halfN);
      phaseQ <= (nextCnt == '0);
    end else begin
      halfQ  <= 1'b0;
      slowQ  <= 1'b0;
      phaseQ <= 1'b0;
    end
  end

  assign halfClk   = halfQ;
  assign slowClk   = slowQ;
  assign phaseMark = phaseQ;

  // R1
  half_pulse_chk: assert property (@(posedge clkIn) disable iff (rst)
    halfQ |=> !halfQ);

  // R5
  phase_edge_chk: assert property (@(posedge clkIn) disable iff (rst)
    phaseQ |-> (halfQ && slowQ && $past(!halfQ && !slowQ)));

  // R7
  slow_full_high_chk: assert property (@(posedge clkIn) disable iff (rst)
    $rose(slowQ) |=> slowQ);

  // R8
  hold_pos_chk: assert property (@(posedge clkIn) disable iff (rst)
    !stb.step |=> $stable(cnt));

  // R9
  reset_quiet_chk: assert property (@(posedge clkIn)
    rst |=> (!halfQ && !slowQ && !phaseQ));

endmodule

// File: rtl/dual_ratio_div.sv
module dual_ratio_div #(
  parameter int RATIO_LO = 4,
  parameter int RATIO_HI = 6
) (
  input  logic clkIn,
  input  logic rst,
  input  logic enable,
  input  logic sixMode,
  output logic halfClk,
  output logic slowClk,
  output logic phaseMark
);

  drd_pkg::drd_strobe_t stb;
  logic atTerm;

  drd_ctrl i_ctrl (
    .clkIn  (clkIn),
    .enable (enable),
    .atTerm (atTerm),
    .stb    (stb)
  );

  drd_datapath #(
    .RATIO_LO (RATIO_LO),
    .RATIO_HI (RATIO_HI)
  ) i_dp (
    .clkIn     (clkIn),
    .rst       (rst),
    .sixMode   (sixMode),
    .stb       (stb),
    .atTerm    (atTerm),
    .halfClk   (halfClk),
    .slowClk   (slowClk),
    .phaseMark (phaseMark)
  );

endmodule

// File: tb/test_dual_ratio_div.sv
`timescale 1ns/100ps
module test_dual_ratio_div;

  localparam int LO = 4;
  localparam int HI = 6;

  typedef struct {
    logic  h;
    logic  s;
    logic  p;
    string tag;
  } exp_t;

  logic clkIn = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic sixMode = 1'b0;
  logic halfClk, slowClk, phaseMark;

  int applied = 0;
  int errors = 0;
  int mPos = HI - 1;
  exp_t q[$];

  always #2.5 clkIn = ~clkIn;

  dual_ratio_div #(.RATIO_LO(LO), .RATIO_HI(HI)) i_dual_ratio_div (
    .clkIn(clkIn), .rst(rst), .enable(enable), .sixMode(sixMode),
    .halfClk(halfClk), .slowClk(slowClk), .phaseMark(phaseMark)
  );

  // Model built from the period rules: position within the slow period
  function automatic exp_t predict(logic e, logic s, logic r, string tag);
    exp_t x;
    int n = s ? HI : LO;
    x.tag = tag;
    x.h = 0; x.s = 0; x.p = 0;
    if (r) mPos = HI - 1;
    else if (e || mPos < n - 1) begin
      mPos = (mPos >= n - 1) ? 0 : mPos + 1;
      x.h = (mPos % 2 == 0);
      x.s = (mPos < n / 2);
      x.p = (mPos == 0);
    end
    return x;
  endfunction

  task automatic compare(exp_t x);
    applied++;
    if (halfClk !== x.h || slowClk !== x.s || phaseMark !== x.p) begin
      errors++;
      $display("FAIL %s at %0t: got half/slow/phase=%b%b%b expected %b%b%b",
               x.tag, $time, halfClk, slowClk, phaseMark, x.h, x.s, x.p);
    end
  endtask

  // Driver: inputs set after a rising edge act on the next rising edge
  task automatic step_cyc(logic e, logic s, logic r, string tag);
    @(posedge clkIn);
    #1;
    enable = e; sixMode = s; rst = r;
    q.push_back(predict(e, s, r, tag));
  endtask

  // Monitor: scoreboard pops plus phase-length and coincidence checks
  logic prevHalf = 0, prevSlow = 0;
  int slowRun = 0;
  always @(posedge clkIn) begin
    #0.5;
    if (q.size() > 0) compare(q.pop_front());
    if (rst) slowRun = 0;
    else begin
      if (prevHalf && halfClk) begin
        applied++; errors++;
        $display("FAIL R1 at %0t: half high run got 2+ expected 1", $time);
      end
      if (slowClk && !prevSlow) begin
        applied++;
        if (!(halfClk && !prevHalf)) begin
          errors++;
          $display("FAIL R4 at %0t: half rise got %b expected 1", $time, halfClk && !prevHalf);
        end
      end
      if (slowClk) slowRun++;
      else if (prevSlow) begin
        applied++;
        if (slowRun != (sixMode ? HI/2 : LO/2)) begin
          errors++;
          $display("FAIL R7 at %0t: slow high run got %0d expected %0d",
                   $time, slowRun, sixMode ? HI/2 : LO/2);
        end
        slowRun = 0;
      end
    end
    prevHalf = halfClk;
    prevSlow = slowClk;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog at %0t: got running expected done", $time);
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

  initial begin
    exp_t x;
    // R9: reset state
    repeat (3) step_cyc(0, 0, 1, "R9");
    // R1/R2/R4/R5: divide-by-4 running, first edge rises together
    repeat (14) step_cyc(1, 0, 0, "R1/R2/R5");
    // R7/R8: stop mid-period, finish it, then hold low
    repeat (6) step_cyc(0, 0, 0, "R7/R8");
    // R6: raise run request just after a falling edge
    @(posedge clkIn);
    @(negedge clkIn);
    #0.5 enable = 1;
    @(posedge clkIn);
    #0.6;
    x = predict(0, 0, 0, "R6");
    compare(x);
    @(posedge clkIn);
    #0.6;
    x = predict(1, 0, 0, "R10");
    compare(x);
    q.push_back(predict(1, 0, 0, "R1/R2"));
    // Park, then change mode under reset
    repeat (3) step_cyc(0, 0, 0, "R7/R8");
    step_cyc(0, 1, 1, "R9");
    // R3: divide-by-6 running
    repeat (20) step_cyc(1, 1, 0, "R3/R4/R5");
    // R9: reset mid-period, then restart together
    step_cyc(1, 1, 1, "R9");
    repeat (7) step_cyc(1, 1, 0, "R9/R3");
    // R7/R8/R10 in divide-by-6
    repeat (8) step_cyc(0, 1, 0, "R7/R8");
    repeat (4) step_cyc(1, 1, 0, "R10/R3");
    repeat (3) @(posedge clkIn);
    #1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, errors);
    $finish;
  end

endmodule